// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block combines four reset requests into a single registered chip reset. The requests are a power-on detector, a supply-low comparator, an active-low external master-clear pin and a one-cycle watchdog timeout. Each request arrives as a synchronous digital input. A power-up timer holds the reset for a programmable number of ticks from a slow oscillator, but only after a power-on or a brown-out event. The timer restarts whenever the supply dips again while it is still counting.

The brown-out path qualifies the comparator in two steps. A two-bit mode field, a software enable bit and a sleep indication first decide whether the detector counts at all. A duration filter then rejects dips shorter than a set number of clock cycles. The external pin passes through its own pulse filter, and a configuration bit can ignore the pin completely. A cause code reports the source of the most recent reset. Software can read and clear two sticky flags that record power-on and brown-out events.

Top module: `chip_reset_sequencer`

## Requirements
- R1: While `por_req` is high, `chip_rst` is 1 from the next clock edge, `rst_cause` reads 0 (power-on) and `flag_por` is set.
- R2: With `cfg_pwrt_off` = 0, after a power-on or brown-out request ends, `chip_rst` stays 1 until `PWRT_TERM` cycles with `lf_tick` high have been counted. It falls one edge after the tick that completes the count.
- R3: With `cfg_pwrt_off` = 1, `chip_rst` falls on the first edge at which no request is active.
- R4: Brown-out detection is enabled as follows, by `cfg_bor_mode`:
  - 0: never enabled.
  - 1: enabled only while `cfg_sw_bor_en` is 1.
  - 2: enabled while `sleep_mode` is 0.
  - 3: always enabled.
- R5: In mode 2, `cfg_sw_bor_en` has no effect. In every mode other than 2, `sleep_mode` has no effect.
- R6: An enabled `bod_below` causes a reset only after it has been high for `BOR_MIN` consecutive cycles. Shorter dips leave `chip_rst` and `flag_bor` unchanged.
- R7: A low `mclr_pin_n` causes a reset only after it has been low for `MCLR_MIN` consecutive cycles. It never starts the power-up timer.
- R8: With `cfg_mclr_en` = 0, `mclr_pin_n` has no effect.
- R9: `flag_por` and `flag_bor` are set by their events and cleared by `flag_clr` bits 0 and 1 respectively. A set condition overrides a clear in the same cycle.
- R10: A `wdt_pulse` with no other request active gives exactly one cycle of `chip_rst` with `rst_cause` = 3. It does not start the power-up timer.
- R11: A qualified brown-out while the power-up timer runs clears its count. A full `PWRT_TERM` delay follows once the brown-out ends.
- R12: `rst_cause` codes are 0 power-on, 1 brown-out, 2 master-clear and 3 watchdog. When several requests are active at once, the priority is power-on, then brown-out, then master-clear, then watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on detector output, active high; also resets the block |
| bod_below | input | 1 | Supply below brown-out threshold |
| mclr_pin_n | input | 1 | External master-clear pin, active low |
| wdt_pulse | input | 1 | Watchdog timeout pulse |
| lf_tick | input | 1 | One-cycle tick from the low-frequency oscillator |
| cfg_bor_mode | input | 2 | Brown-out mode select |
| cfg_sw_bor_en | input | 1 | Software brown-out enable |
| sleep_mode | input | 1 | Device is sleeping |
| cfg_pwrt_off | input | 1 | 1 disables the power-up timer |
| cfg_mclr_en | input | 1 | 1 honours the master-clear pin |
| flag_clr | input | 2 | Clear strobes: bit 0 power-on flag, bit 1 brown-out flag |
| chip_rst | output | 1 | Combined chip reset, active high |
| rst_cause | output | 2 | Source of the last reset |
| flag_por | output | 1 | Sticky power-on flag |
| flag_bor | output | 1 | Sticky brown-out flag |

## Verification
The embedded assertions check the following on every cycle:
- A filter output can only rise after its input was high.
- The power-up count holds between ticks.
- Reset stays asserted while the timer is busy.
- A qualified brown-out always sets its flag.
- A lone watchdog pulse yields a one-cycle reset with the watchdog cause.

Only the bench scenarios can show the rest. These are the mode and sleep decode across all combinations, the exact lengths at which dips and pin pulses start to count, and the full timer delay after tick counting. They also cover the restart of the delay by a brown-out in mid-count, the cause priority under overlapping requests, and the flag clear behaviour.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [1:0] {
      BOR_OFF   = 2'd0,
      BOR_SW    = 2'd1,
      BOR_AWAKE = 2'd2,
      BOR_ON    = 2'd3
   } bor_mode_e;

   typedef enum logic [1:0] {
      CAUSE_POR  = 2'd0,
      CAUSE_BOR  = 2'd1,
      CAUSE_MCLR = 2'd2,
      CAUSE_WDT  = 2'd3
   } rst_cause_e;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit + 1) : 1;
   endfunction

endpackage

// File: rtl/rst_pulse_filter.sv
module rst_pulse_filter
   import rst_seq_pkg::*;
#(
   parameter int LEN = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic pass
);

   generate
      if (LEN < 0) begin : g_bad
         $error("rst_pulse_filter: LEN must not be negative");
      end

      if (LEN == 0) begin : g_direct
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= raw;
         end
         assign pass = q;
      end else begin : g_count
         localparam int CW = cnt_width(LEN);
         localparam logic [CW-1:0] LIM = CW'(LEN);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst)           cnt <= '0;
            else if (!raw)     cnt <= '0;
            else if (cnt != LIM) cnt <= cnt + 1'b1;
         end
         assign pass = (cnt == LIM);

         // R6 R7
         rose_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pass) |-> $past(raw));
         // R6 R7
         drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
            !raw |=> !pass);
      end
   endgenerate

endmodule

// File: rtl/rst_bor_gate.sv
module rst_bor_gate
   import rst_seq_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       sw_en,
   input  logic       sleeping,
   output logic       det_en
);

   bor_mode_e m;
   assign m = bor_mode_e'(mode);

   always_comb begin
      unique case (m)
         BOR_OFF:   det_en = 1'b0;
         BOR_SW:    det_en = sw_en;
         BOR_AWAKE: det_en = !sleeping;
         BOR_ON:    det_en = 1'b1;
         default:   det_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/rst_pwrt.sv
module rst_pwrt
   import rst_seq_pkg::*;
#(
   parameter int TERM = 2048
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic enable,
   input  logic lf_tick,
   output logic busy
);

   localparam int CW = cnt_width(TERM);
   localparam logic [CW-1:0] LAST = CW'(TERM - 1);

   generate
      if (TERM < 1) begin : g_bad
         $error("rst_pwrt: TERM must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         busy <= enable;
         cnt  <= '0;
      end else if (busy && lf_tick) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !restart && !lf_tick) |=> ($stable(cnt) && busy));

endmodule

// File: rtl/chip_reset_sequencer.sv
module chip_reset_sequencer
   import rst_seq_pkg::*;
#(
   parameter int PWRT_TERM = 2048,
   parameter int BOR_MIN   = 16,
   parameter int MCLR_MIN  = 8
) (
   input  logic       clk,
   input  logic       por_req,
   input  logic       bod_below,
   input  logic       mclr_pin_n,
   input  logic       wdt_pulse,
   input  logic       lf_tick,
   input  logic [1:0] cfg_bor_mode,
   input  logic       cfg_sw_bor_en,
   input  logic       sleep_mode,
   input  logic       cfg_pwrt_off,
   input  logic       cfg_mclr_en,
   input  logic [1:0] flag_clr,
   output logic       chip_rst,
   output logic [1:0] rst_cause,
   output logic       flag_por,
   output logic       flag_bor
);

   logic bor_en, bor_hit, mclr_hit, pwrt_busy;

   rst_bor_gate u_gate (
      .mode     (cfg_bor_mode),
      .sw_en    (cfg_sw_bor_en),
      .sleeping (sleep_mode),
      .det_en   (bor_en)
   );

   rst_pulse_filter #(.LEN(BOR_MIN)) u_bor_filt (
      .clk  (clk),
      .rst  (por_req),
      .raw  (bod_below && bor_en),
      .pass (bor_hit)
   );

   rst_pulse_filter #(.LEN(MCLR_MIN)) u_mclr_filt (
      .clk  (clk),
      .rst  (por_req),
      .raw  (cfg_mclr_en && !mclr_pin_n),
      .pass (mclr_hit)
   );

   rst_pwrt #(.TERM(PWRT_TERM)) u_pwrt (
      .clk     (clk),
      .rst     (por_req),
      .restart (bor_hit),
      .enable  (!cfg_pwrt_off),
      .lf_tick (lf_tick),
      .busy    (pwrt_busy)
   );

   logic any_src;
   assign any_src = por_req || bor_hit || mclr_hit || wdt_pulse;

   always_ff @(posedge clk) begin
      chip_rst <= any_src || pwrt_busy;
      if (por_req)        rst_cause <= CAUSE_POR;
      else if (bor_hit)   rst_cause <= CAUSE_BOR;
      else if (mclr_hit)  rst_cause <= CAUSE_MCLR;
      else if (wdt_pulse) rst_cause <= CAUSE_WDT;

      if (por_req)          flag_por <= 1'b1;
      else if (flag_clr[0]) flag_por <= 1'b0;

      if (por_req)          flag_bor <= 1'b0;
      else if (bor_hit)     flag_bor <= 1'b1;
      else if (flag_clr[1]) flag_bor <= 1'b0;
   end

   // R2
   pwrt_holds_rst_chk: assert property (@(posedge clk) disable iff (por_req)
      pwrt_busy |=> chip_rst);
   // R9
   bor_sets_flag_chk: assert property (@(posedge clk) disable iff (por_req)
      bor_hit |=> flag_bor);
   // R10
   wdt_only_chk: assert property (@(posedge clk) disable iff (por_req)
      (wdt_pulse && !bor_hit && !mclr_hit) |=> (chip_rst && rst_cause == CAUSE_WDT));

endmodule

// File: tb/chip_reset_sequencer_test.sv
module chip_reset_sequencer_test;

   localparam int TERM = 8;
   localparam int BMIN = 4;
   localparam int MMIN = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       por_req = 1'b1, bod_below = 1'b0, mclr_pin_n = 1'b1, wdt_pulse = 1'b0;
   logic       lf_tick = 1'b0, cfg_sw_bor_en = 1'b0, sleep_mode = 1'b0;
   logic       cfg_pwrt_off = 1'b1, cfg_mclr_en = 1'b1;
   logic [1:0] cfg_bor_mode = 2'd3, flag_clr = 2'd0;
   logic       chip_rst, flag_por, flag_bor;
   logic [1:0] rst_cause;

   chip_reset_sequencer #(.PWRT_TERM(TERM), .BOR_MIN(BMIN), .MCLR_MIN(MMIN)) uut (
      .clk(clk), .por_req(por_req), .bod_below(bod_below), .mclr_pin_n(mclr_pin_n),
      .wdt_pulse(wdt_pulse), .lf_tick(lf_tick), .cfg_bor_mode(cfg_bor_mode),
      .cfg_sw_bor_en(cfg_sw_bor_en), .sleep_mode(sleep_mode), .cfg_pwrt_off(cfg_pwrt_off),
      .cfg_mclr_en(cfg_mclr_en), .flag_clr(flag_clr), .chip_rst(chip_rst),
      .rst_cause(rst_cause), .flag_por(flag_por), .flag_bor(flag_bor));

   int checks = 0, errors = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) lf_tick = 1'b1;
      @(negedge clk) lf_tick = 1'b0;
      cyc(2);
   endtask

   task automatic clear_flags();
      @(negedge clk) flag_clr = 2'b11;
      @(negedge clk) flag_clr = 2'b00;
   endtask

   // {mode[1:0], sw_en, sleep, expect_reset}
   localparam logic [4:0] VEC [8] = '{
      5'b00_1_0_0, 5'b01_0_0_0, 5'b01_1_0_1, 5'b01_1_1_1,
      5'b10_0_0_1, 5'b10_0_1_0, 5'b10_1_1_0, 5'b11_0_1_1 };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 power-on reset state
      cyc(4);
      check("R1 chip_rst during por", chip_rst, 1);
      check("R1 cause power-on", rst_cause, 0);
      check("R1 flag_por", flag_por, 1);
      check("R9 flag_bor cleared by por", flag_bor, 0);
      por_req = 1'b0;
      cyc(1);
      check("R3 release without timer", chip_rst, 0);
      clear_flags();
      check("R9 flag_por cleared", flag_por, 0);

      // R4 R5 mode decode table
      foreach (VEC[i]) begin
         cfg_bor_mode  = VEC[i][4:3];
         cfg_sw_bor_en = VEC[i][2];
         sleep_mode    = VEC[i][1];
         clear_flags();
         bod_below = 1'b1;
         cyc(BMIN + 3);
         check($sformatf("R4 R5 vec %0d reset", i), chip_rst, VEC[i][0]);
         bod_below = 1'b0;
         cyc(3);
         check($sformatf("R4 R5 vec %0d flag_bor", i), flag_bor, VEC[i][0]);
         check($sformatf("R4 vec %0d released", i), chip_rst, 0);
      end
      sleep_mode = 1'b0;
      cfg_bor_mode = 2'd3;

      // R6 short dip ignored, exact-length dip counts
      begin
         int seen = 0;
         clear_flags();
         bod_below = 1'b1;
         for (int k = 0; k < BMIN - 1; k++) begin
            @(negedge clk);
            if (chip_rst) seen = 1;
         end
         bod_below = 1'b0;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (chip_rst) seen = 1;
         end
         check("R6 short dip no reset", seen, 0);
         check("R6 short dip no flag", flag_bor, 0);
         bod_below = 1'b1;
         cyc(BMIN + 1);
         check("R6 full dip resets", chip_rst, 1);
         check("R12 cause brown-out", rst_cause, 1);
         bod_below = 1'b0;
         cyc(3);
      end

      // R7 master-clear filter, timer enabled to show it is not used
      cfg_pwrt_off = 1'b0;
      begin
         int seen = 0;
         mclr_pin_n = 1'b0;
         for (int k = 0; k < MMIN - 1; k++) begin
            @(negedge clk);
            if (chip_rst) seen = 1;
         end
         mclr_pin_n = 1'b1;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (chip_rst) seen = 1;
         end
         check("R7 short pin pulse ignored", seen, 0);
      end
      mclr_pin_n = 1'b0;
      cyc(MMIN + 2);
      check("R7 long pin pulse resets", chip_rst, 1);
      check("R12 cause master-clear", rst_cause, 2);
      mclr_pin_n = 1'b1;
      cyc(3);
      check("R7 no timer after master-clear", chip_rst, 0);

      // R8 pin disabled
      cfg_mclr_en = 1'b0;
      mclr_pin_n = 1'b0;
      cyc(MMIN + 4);
      check("R8 disabled pin no reset", chip_rst, 0);
      check("R8 cause unchanged", rst_cause, 2);
      mclr_pin_n = 1'b1;
      cfg_mclr_en = 1'b1;

      // R10 watchdog pulse
      @(negedge clk) wdt_pulse = 1'b1;
      @(negedge clk) wdt_pulse = 1'b0;
      check("R10 wdt reset asserted", chip_rst, 1);
      check("R10 cause watchdog", rst_cause, 3);
      cyc(1);
      check("R10 one-cycle only, no timer", chip_rst, 0);
      check("R10 flag_bor untouched", flag_bor, 1);

      // R2 timer after power-on
      por_req = 1'b1;
      cyc(3);
      por_req = 1'b0;
      for (int k = 0; k < TERM - 1; k++) tick();
      check("R2 held before last tick", chip_rst, 1);
      tick();
      check("R2 released after last tick", chip_rst, 0);

      // R11 brown-out in mid-count restarts the delay
      por_req = 1'b1;
      cyc(3);
      por_req = 1'b0;
      for (int k = 0; k < 4; k++) tick();
      bod_below = 1'b1;
      cyc(BMIN + 2);
      bod_below = 1'b0;
      cyc(2);
      for (int k = 0; k < TERM - 1; k++) tick();
      check("R11 still held after restart", chip_rst, 1);
      tick();
      check("R11 released after full delay", chip_rst, 0);
      check("R12 cause brown-out after restart", rst_cause, 1);
      cfg_pwrt_off = 1'b1;

      // R12 priority: brown-out over master-clear, master-clear over watchdog
      mclr_pin_n = 1'b0;
      cyc(MMIN + 2);
      @(negedge clk) wdt_pulse = 1'b1;
      @(negedge clk) wdt_pulse = 1'b0;
      check("R12 master-clear over watchdog", rst_cause, 2);
      bod_below = 1'b1;
      cyc(BMIN + 2);
      check("R12 brown-out over master-clear", rst_cause, 1);

      // R9 set overrides clear, then clear works
      @(negedge clk) flag_clr = 2'b10;
      @(negedge clk) flag_clr = 2'b00;
      check("R9 set beats clear", flag_bor, 1);
      bod_below = 1'b0;
      mclr_pin_n = 1'b1;
      cyc(3);
      @(negedge clk) flag_clr = 2'b10;
      @(negedge clk) flag_clr = 2'b00;
      check("R9 flag_bor cleared", flag_bor, 0);
      check("R3 released", chip_rst, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule